// File: doc/BRIEF.md
# Wormhole Virtual-Channel Router Input Port

This block is one input port of a wormhole-switched on-chip router. The link delivers one flit per cycle. A flit is as wide as the link and carries a 2-bit type and an upstream packet tag. The port does not segment packets. It holds several small per-channel flit buffers, called virtual channels. Each new packet, starting with its head flit, is placed into a free virtual channel. The rest of the packet follows that channel until its tail.

The virtual channels compete for one output link. A channel is eligible when it holds a flit and has a downstream credit left. A round-robin arbiter grants one eligible channel per cycle. A packet that is stalled for lack of credits therefore blocks only its own channel, and the other channels keep using the link.

When a head flit reaches the output, its low destination bits are looked up in a parameter table. The result is an output-port number, which travels with every flit of that packet. If the port has no room for a flit, it refuses the flit by holding the ready signal low. It never drops a flit.

Top module: `vc_input_port`

## Requirements
- R1: After reset, every virtual channel is free and its buffer is empty, each channel holds CREDITS credits, out_valid is low, and a head flit sees in_ready high.
- R2: Flit type encoding is 00 head, 01 body, 10 tail and 11 single. A head or single flit claims the lowest-numbered free virtual channel. Body and tail flits go to the channel that the open packet of the same in_tag was given.
- R3: The flits of one virtual channel leave in arrival order, with type and data unchanged. out_vc names the channel that sent the flit.
- R4: The port refuses a flit by holding in_ready low, and a refused flit is not stored. A head or single flit is refused when all channels are claimed. A body or tail flit is refused when its tag has no open packet, or when its channel already holds VC_DEPTH flits.
- R5: A virtual channel stays claimed until its tail or single flit is sent on the output. From the next cycle on, it is free for a new head.
- R6: Each channel keeps a credit count. Sending a flit lowers it by one, and a return (cr_valid with cr_vc) raises it by one. A send and a return on the same channel in the same cycle leave it unchanged. A channel with zero credits does not send.
- R7: The output sends at most one flit per cycle. It grants the first eligible channel in circular order after the last granted one. After reset, channel 0 comes first.
- R8: A channel that is blocked for lack of credits does not stop other eligible channels from sending.
- R9: out_port equals ROUTE_MAP entry d, where d is the low DEST_W bits of the packet's head data. With the default table, destination d maps to port 3-d. Every flit of the packet carries the same out_port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Flit offered by upstream |
| in_type | input | 2 | Flit type (00 head, 01 body, 10 tail, 11 single) |
| in_tag | input | VID_W | Upstream packet tag |
| in_data | input | FLIT_W | Flit payload; the low DEST_W bits of a head are the destination |
| in_ready | output | 1 | Flit is accepted this cycle when in_valid is also high |
| out_valid | output | 1 | A flit is sent this cycle |
| out_vc | output | VID_W | Virtual channel of the sent flit |
| out_type | output | 2 | Type of the sent flit |
| out_data | output | FLIT_W | Payload of the sent flit |
| out_port | output | PORT_W | Routed output port of the packet |
| cr_valid | input | 1 | Downstream returns one credit |
| cr_vc | input | VID_W | Channel the credit belongs to |

## Verification
Several functions can fall in the same cycle. A flit can be sent on a channel while a credit for that same channel returns. A tail can leave one channel while a new head claims a channel and another flit is written into the same buffer. The bench uses a pseudo-random upstream that respects the packet rules, and it returns credits in three phases: freely, not at all, and only to even channels. This drives these coincidences often, and it also drives credit starvation and refusal. A behavioural reference model built from queues and counters predicts in_ready and every output field on every cycle, and each mismatch is reported against the requirement it breaks.

// File: rtl/vc_input_port.sv
module vc_input_port #(
  parameter int FLIT_W   = 16,
  parameter int NUM_VC   = 4,
  parameter int VC_DEPTH = 4,
  parameter int CREDITS  = 4,
  parameter int DEST_W   = 2,
  parameter int PORT_W   = 2,
  parameter logic [(2**DEST_W)*PORT_W-1:0] ROUTE_MAP = {2'd0, 2'd1, 2'd2, 2'd3},
  localparam int VID_W = $clog2(NUM_VC),
  localparam int PTR_W = $clog2(VC_DEPTH),
  localparam int CNT_W = $clog2(VC_DEPTH + 1),
  localparam int CR_W  = $clog2(CREDITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_type,
  input  logic [VID_W-1:0]  in_tag,
  input  logic [FLIT_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [VID_W-1:0]  out_vc,
  output logic [1:0]        out_type,
  output logic [FLIT_W-1:0] out_data,
  output logic [PORT_W-1:0] out_port,
  input  logic              cr_valid,
  input  logic [VID_W-1:0]  cr_vc
);
  localparam logic [1:0] T_HEAD = 2'b00, T_TAIL = 2'b10, T_SINGLE = 2'b11;

  logic [FLIT_W+1:0] buf_mem [NUM_VC][VC_DEPTH];
  logic [PTR_W-1:0]  wr_ptr  [NUM_VC];
  logic [PTR_W-1:0]  rd_ptr  [NUM_VC];
  logic [CNT_W-1:0]  fill    [NUM_VC];
  logic [CR_W-1:0]   cred    [NUM_VC];
  logic [PORT_W-1:0] route   [NUM_VC];
  logic [VID_W-1:0]  tag_vc  [NUM_VC];
  logic [NUM_VC-1:0] busy, tag_live, elig;
  logic [VID_W-1:0]  last_gnt, free_vc, tgt_vc, gnt;
  logic              free_any, gnt_any, push, in_head, out_last;
  logic [FLIT_W+1:0] out_flit;

  assign in_head = (in_type == T_HEAD) || (in_type == T_SINGLE);

  always_comb begin
    free_any = 1'b0;
    free_vc  = '0;
    for (int v = NUM_VC - 1; v >= 0; v--)
      if (!busy[v]) begin
        free_any = 1'b1;
        free_vc  = VID_W'(v);
      end
  end

  assign tgt_vc   = in_head ? free_vc : tag_vc[in_tag];
  assign in_ready = in_head ? free_any
                  : (tag_live[in_tag] && fill[tag_vc[in_tag]] != CNT_W'(VC_DEPTH));
  assign push     = in_valid && in_ready;

  always_comb
    for (int v = 0; v < NUM_VC; v++)
      elig[v] = (fill[v] != '0) && (cred[v] != '0);

  always_comb begin
    int idx;
    gnt_any = 1'b0;
    gnt     = '0;
    for (int k = 1; k <= NUM_VC; k++) begin
      idx = (int'(last_gnt) + k) % NUM_VC;
      if (!gnt_any && elig[idx]) begin
        gnt_any = 1'b1;
        gnt     = VID_W'(idx);
      end
    end
  end

  assign out_flit  = buf_mem[gnt][rd_ptr[gnt]];
  assign out_valid = gnt_any;
  assign out_vc    = gnt;
  assign out_type  = out_flit[FLIT_W+1:FLIT_W];
  assign out_data  = out_flit[FLIT_W-1:0];
  assign out_port  = route[gnt];
  assign out_last  = (out_type == T_TAIL) || (out_type == T_SINGLE);

  always_ff @(posedge clk)
    if (push) buf_mem[tgt_vc][wr_ptr[tgt_vc]] <= {in_type, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= '0;
      tag_live <= '0;
      last_gnt <= VID_W'(NUM_VC - 1);
      for (int v = 0; v < NUM_VC; v++) begin
        wr_ptr[v] <= '0;
        rd_ptr[v] <= '0;
        fill[v]   <= '0;
        cred[v]   <= CR_W'(CREDITS);
        route[v]  <= '0;
        tag_vc[v] <= '0;
      end
    end else begin
      if (gnt_any) last_gnt <= gnt;
      for (int v = 0; v < NUM_VC; v++) begin
        logic pv, gv, rv;
        pv = push && (tgt_vc == VID_W'(v));
        gv = gnt_any && (gnt == VID_W'(v));
        rv = cr_valid && (cr_vc == VID_W'(v));
        if (pv) wr_ptr[v] <= (wr_ptr[v] == PTR_W'(VC_DEPTH - 1)) ? '0 : wr_ptr[v] + 1'b1;
        if (gv) rd_ptr[v] <= (rd_ptr[v] == PTR_W'(VC_DEPTH - 1)) ? '0 : rd_ptr[v] + 1'b1;
        if (pv && !gv) fill[v] <= fill[v] + 1'b1;
        else if (gv && !pv) fill[v] <= fill[v] - 1'b1;
        if (rv && !gv) cred[v] <= cred[v] + 1'b1;
        else if (gv && !rv) cred[v] <= cred[v] - 1'b1;
        if (pv && in_head) begin
          busy[v]  <= 1'b1;
          route[v] <= ROUTE_MAP[in_data[DEST_W-1:0]*PORT_W +: PORT_W];
        end else if (gv && out_last) busy[v] <= 1'b0;
        if (push && in_tag == VID_W'(v)) begin
          if (in_type == T_HEAD) begin
            tag_live[v] <= 1'b1;
            tag_vc[v]   <= free_vc;
          end else if (in_type == T_TAIL) tag_live[v] <= 1'b0;
        end
      end
    end
  end

  AST_SEND_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cred[out_vc] != '0);  // R6
  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> cred[cr_vc] < CR_W'(CREDITS));  // R6
  AST_REFUSE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_head && &busy) |-> !in_ready);  // R4
  AST_RELEASE_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> !busy[$past(out_vc)]);  // R5
  AST_SEND_FROM_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy[out_vc]);  // R3
endmodule

// File: tb/vc_input_port_tb.sv
module vc_input_port_tb;
  localparam int CLK_P = 10;
  localparam int NV = 4, DEP = 4, CRD = 4, FW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, cr_valid = 1'b0;
  logic [1:0] in_type = 2'b00;
  logic [1:0] in_tag = '0, cr_vc = '0;
  logic [FW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [1:0] out_vc, out_type, out_port;
  logic [FW-1:0] out_data;

  vc_input_port u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type), .in_tag(in_tag),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid), .out_vc(out_vc),
    .out_type(out_type), .out_data(out_data), .out_port(out_port),
    .cr_valid(cr_valid), .cr_vc(cr_vc));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [FW+1:0] mq [NV][$];
  bit mbusy[NV], mlive[NV], up_open[NV];
  int mtag[NV], mcred[NV], mroute[NV], owed[NV], up_left[NV];
  int mlast;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(int mode, bit drive_in);
    bit ev, hd, er;
    int fv, tv, g, ret;
    @(negedge clk);
    ev = drive_in && ($urandom % 4 != 0);
    in_valid = ev;
    in_tag = 2'($urandom % NV);
    if (!up_open[in_tag]) in_type = ($urandom % 3 == 0) ? 2'b11 : 2'b00;
    else in_type = (up_left[in_tag] == 0) ? 2'b10 : 2'b01;
    in_data = 16'($urandom);
    ret = -1;
    for (int k = 0; k < NV; k++) begin
      int v;
      v = ($urandom % NV + k) % NV;
      if (ret < 0 && owed[v] > 0 && (mode == 0 || (mode == 2 && v % 2 == 0)) && $urandom % 2 == 0)
        ret = v;
    end
    cr_valid = (ret >= 0);
    cr_vc = 2'(ret < 0 ? 0 : ret);
    #1;
    hd = (in_type == 2'b00) || (in_type == 2'b11);
    fv = -1;
    for (int v = NV - 1; v >= 0; v--) if (!mbusy[v]) fv = v;
    tv = hd ? fv : mtag[in_tag];
    er = hd ? (fv >= 0) : (mlive[in_tag] && mq[mtag[in_tag]].size() < DEP);
    chk(in_ready == er, "R4/R2/R5", "in_ready", in_ready, er);
    g = -1;
    for (int k = 1; k <= NV; k++) begin
      int i;
      i = (mlast + k) % NV;
      if (g < 0 && mq[i].size() > 0 && mcred[i] > 0) g = i;
    end
    chk(out_valid == (g >= 0), "R7/R6/R8", "out_valid", out_valid, g >= 0);
    if (g >= 0 && out_valid) begin
      chk(out_vc == 2'(g), "R7/R8", "out_vc", out_vc, g);
      chk({out_type, out_data} == mq[g][0], "R3", "out_flit", {out_type, out_data}, mq[g][0]);
      chk(out_port == 2'(mroute[g]), "R9", "out_port", out_port, mroute[g]);
    end
    @(posedge clk);
    if (g >= 0) begin
      logic [FW+1:0] f;
      f = mq[g].pop_front();
      mcred[g]--; owed[g]++; mlast = g;
      if (f[FW+1:FW] == 2'b10 || f[FW+1:FW] == 2'b11) mbusy[g] = 1'b0;
    end
    if (ret >= 0) begin mcred[ret]++; owed[ret]--; end
    if (ev && er) begin
      mq[tv].push_back({in_type, in_data});
      if (hd) begin mbusy[tv] = 1'b1; mroute[tv] = 3 - int'(in_data[1:0]); end
      case (in_type)
        2'b00: begin mlive[in_tag] = 1'b1; mtag[in_tag] = tv;
                     up_open[in_tag] = 1'b1; up_left[in_tag] = $urandom % 3; end
        2'b01: up_left[in_tag]--;
        2'b10: begin mlive[in_tag] = 1'b0; up_open[in_tag] = 1'b0; end
        default: ;
      endcase
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      mcred[v] = CRD; mbusy[v] = 0; mlive[v] = 0; up_open[v] = 0;
      owed[v] = 0; up_left[v] = 0; mtag[v] = 0; mroute[v] = 0;
    end
    mlast = NV - 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    in_type = 2'b00;
    #1;
    chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    for (int i = 0; i < 1500; i++) step(0, 1'b1);
    for (int i = 0; i < 300; i++) step(1, 1'b1);
    for (int i = 0; i < 800; i++) step(2, 1'b1);
    for (int i = 0; i < 800; i++) step(0, 1'b1);
    for (int i = 0; i < 200; i++) step(0, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule